// File: doc/BRIEF.md
# Bunch-Train Power and Time-Stamp Sequencer

This block steps one pixel sensor through the repeating cycle of a collider bunch train. While the sensor is idle, power to its analog front ends is off. A train-start strobe switches that power on and clears every pixel hit latch with a single-cycle master-clear pulse. The block then waits a configurable settling interval so the analog section can recover from the power-on transient, and only after that opens the acquisition window.

During acquisition the block counts per-crossing strobes. It drives a narrow time-stamp bus that every pixel samples when it is hit. The stamp advances once per group of crossings, so that a whole train of several thousand crossings fits within the stamp's code range. After the last crossing of the train, the block cuts the analog power, closes acquisition and pulses a readout-start line. It then waits for the readout logic to report completion before it returns to idle.

A train-start strobe that arrives when the block is not idle has no effect on the sequence, and it sets a sticky error flag.

Top module: `stw_train_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is low: `afe_power_en`, `acq_en`, `readout_start`, `pix_master_clr`, `seq_error` and `time_stamp` (value 0).
- R2: A `train_start` pulse seen in idle makes `afe_power_en` high and `pix_master_clr` high on the next cycle. `pix_master_clr` stays high for exactly that one cycle. `time_stamp` reads 0 in that cycle, even if the previous train left it at a nonzero value.
- R3: `acq_en` rises exactly `SETTLE_CYC` cycles after `afe_power_en` rises. `afe_power_en` stays high for the whole settling interval and the whole acquisition window, and `acq_en` is never high while `afe_power_en` is low.
- R4: During acquisition, after k crossing strobes, `time_stamp` equals the smaller of floor(k / `PRESCALE`) and 2^`STAMP_W` - 1. The stamp saturates at the all-ones code and never wraps.
- R5: Crossing strobes given while the block is idle, settling or in readout change neither `time_stamp` nor the number of crossings that acquisition needs to finish.
- R6: On the cycle after the `TRAIN_XINGS`-th crossing strobe of acquisition, `acq_en` and `afe_power_en` are low and `readout_start` is high for exactly one cycle.
- R7: After `readout_start`, the block keeps power off and waits until `readout_done` is seen, then returns to idle and accepts the next `train_start`. A `readout_done` seen during acquisition has no effect.
- R8: A `train_start` seen while the block is not idle leaves power, acquisition, the master clear and the stamp unchanged. It sets `seq_error`, which stays high until reset.
- R9: `time_stamp` holds its last acquisition value through the readout phase and back into idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | One-cycle strobe marking an upcoming bunch train |
| xing_strobe | input | 1 | One-cycle strobe per beam crossing |
| readout_done | input | 1 | Readout logic has finished draining the hits |
| afe_power_en | output | 1 | Power enable for the analog front ends |
| acq_en | output | 1 | Acquisition window open |
| readout_start | output | 1 | One-cycle pulse that starts the readout |
| pix_master_clr | output | 1 | One-cycle pulse that clears every pixel hit latch |
| time_stamp | output | STAMP_W | Time-stamp bus sampled by the pixels |
| seq_error | output | 1 | Sticky flag: train start seen while not idle |

## Verification
The assertions assume that the inputs are synchronous to `clk`. They also assume that the train, crossing and done strobes take effect only at the rising edge where they are high, so a strobe held for several cycles counts once per cycle. The bench drives every strobe on the falling edge for exactly one cycle and samples outputs on the falling edge. Each crossing in the acquisition window is therefore counted exactly once. Strobes aimed at the wrong phase (crossings during settling, done during acquisition, train starts during acquisition and readout) are placed deliberately, to exercise the cases the design must ignore.

// File: rtl/stw_pkg.sv
package stw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_ACQ  = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef struct packed {
        logic power_en;
        logic acq_en;
    } rails_t;

    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic rails_t phase_rails(input phase_e ph);
        rails_t r;
        r.power_en = (ph == PH_WARM) || (ph == PH_ACQ);
        r.acq_en   = (ph == PH_ACQ);
        return r;
    endfunction

endpackage

// File: rtl/stw_interval_timer.sv
module stw_interval_timer #(
    parameter int unsigned LIMIT = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = stw_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    AST_SETTLE_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

endmodule

// File: rtl/stw_stamp_gen.sv
module stw_stamp_gen #(
    parameter int unsigned TRAIN_XINGS = 2820,
    parameter int unsigned STAMP_W     = 5,
    parameter int unsigned PRESCALE    = 89
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               active,
    input  logic               xing,
    output logic [STAMP_W-1:0] stamp,
    output logic               train_end
);
    localparam int unsigned XW = stw_pkg::cnt_width(TRAIN_XINGS);
    localparam logic [XW-1:0] XLAST = XW'(TRAIN_XINGS - 1);
    localparam logic [STAMP_W-1:0] SMAX = '1;

    logic [XW-1:0] xcnt;
    logic          counted;
    logic          tick;

    assign counted = active && xing;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            xcnt <= '0;
        end else if (counted && (xcnt != XLAST)) begin
            xcnt <= xcnt + 1'b1;
        end
    end

    assign train_end = counted && (xcnt == XLAST);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = counted;
        end else begin : g_divided
            localparam int unsigned PW = stw_pkg::cnt_width(PRESCALE);
            localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    pcnt <= '0;
                end else if (counted) begin
                    pcnt <= (pcnt == PLAST) ? '0 : pcnt + 1'b1;
                end
            end

            assign tick = counted && (pcnt == PLAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stamp <= '0;
        end else if (tick && (stamp != SMAX)) begin
            stamp <= stamp + 1'b1;
        end
    end

    AST_STAMP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (stamp >= $past(stamp))); // R4
    AST_STAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((stamp - $past(stamp)) <= STAMP_W'(1))); // R4
    AST_STAMP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!active && !clear) |=> $stable(stamp)); // R5

endmodule

// File: rtl/stw_phase_fsm.sv
module stw_phase_fsm
    import stw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   train_start,
    input  logic   settle_done,
    input  logic   train_end,
    input  logic   readout_done,
    output phase_e phase,
    output logic   enter_warm,
    output logic   power_en,
    output logic   acq_en,
    output logic   rd_start,
    output logic   pix_clear,
    output logic   seq_error
);
    phase_e phase_nxt;
    rails_t rails;

    assign enter_warm = (phase == PH_IDLE) && train_start;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (train_start)  phase_nxt = PH_WARM;
            PH_WARM: if (settle_done)  phase_nxt = PH_ACQ;
            PH_ACQ:  if (train_end)    phase_nxt = PH_READ;
            PH_READ: if (readout_done) phase_nxt = PH_IDLE;
            default:                   phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            rd_start  <= 1'b0;
            pix_clear <= 1'b0;
            seq_error <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            rd_start  <= (phase == PH_ACQ) && train_end;
            pix_clear <= enter_warm;
            if (train_start && (phase != PH_IDLE)) begin
                seq_error <= 1'b1;
            end
        end
    end

    assign rails    = phase_rails(phase);
    assign power_en = rails.power_en;
    assign acq_en   = rails.acq_en;

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pix_clear |=> !pix_clear); // R2
    AST_CLEAR_WITH_POWER: assert property (@(posedge clk) disable iff (rst)
        pix_clear |-> (power_en && !acq_en)); // R2
    AST_ACQ_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        acq_en |-> power_en); // R3
    AST_RDSTART_CLOSES_ACQ: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> ($past(acq_en) && !acq_en && !power_en)); // R6
    AST_RDSTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !rd_start); // R6
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_error |=> seq_error); // R8

endmodule

// File: rtl/stw_train_sequencer.sv
module stw_train_sequencer
    import stw_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = 3000,
    parameter int unsigned TRAIN_XINGS = 2820,
    parameter int unsigned STAMP_W     = 5,
    parameter int unsigned PRESCALE    = div_ceil(TRAIN_XINGS, 2 ** STAMP_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               train_start,
    input  logic               xing_strobe,
    input  logic               readout_done,
    output logic               afe_power_en,
    output logic               acq_en,
    output logic               readout_start,
    output logic               pix_master_clr,
    output logic [STAMP_W-1:0] time_stamp,
    output logic               seq_error
);
    phase_e phase;
    logic   enter_warm;
    logic   settle_done;
    logic   train_end;

    stw_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .train_start  (train_start),
        .settle_done  (settle_done),
        .train_end    (train_end),
        .readout_done (readout_done),
        .phase        (phase),
        .enter_warm   (enter_warm),
        .power_en     (afe_power_en),
        .acq_en       (acq_en),
        .rd_start     (readout_start),
        .pix_clear    (pix_master_clr),
        .seq_error    (seq_error)
    );

    stw_interval_timer #(
        .LIMIT (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst   (rst),
        .clear (enter_warm),
        .run   (phase == PH_WARM),
        .done  (settle_done)
    );

    stw_stamp_gen #(
        .TRAIN_XINGS (TRAIN_XINGS),
        .STAMP_W     (STAMP_W),
        .PRESCALE    (PRESCALE)
    ) u_stamp (
        .clk       (clk),
        .rst       (rst),
        .clear     (enter_warm),
        .active    (phase == PH_ACQ),
        .xing      (xing_strobe),
        .stamp     (time_stamp),
        .train_end (train_end)
    );

endmodule

// File: tb/test_stw_train_sequencer.sv
`timescale 1ns/1ps
module test_stw_train_sequencer;
    localparam int S    = 5;
    localparam int T    = 20;
    localparam int W    = 2;
    localparam int P    = 4;
    localparam int SMAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic train_start = 1'b0;
    logic xing_strobe = 1'b0;
    logic readout_done = 1'b0;
    logic afe_power_en, acq_en, readout_start, pix_master_clr, seq_error;
    logic [W-1:0] time_stamp;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stw_train_sequencer #(
        .SETTLE_CYC (S),
        .TRAIN_XINGS(T),
        .STAMP_W    (W),
        .PRESCALE   (P)
    ) i_stw_train_sequencer (
        .clk(clk), .rst(rst), .train_start(train_start), .xing_strobe(xing_strobe),
        .readout_done(readout_done), .afe_power_en(afe_power_en), .acq_en(acq_en),
        .readout_start(readout_start), .pix_master_clr(pix_master_clr),
        .time_stamp(time_stamp), .seq_error(seq_error)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_stamp(input int k);
        return ((k / P) > SMAX) ? SMAX : (k / P);
    endfunction

    task automatic check_all_low(input string req);
        chk({req, " power"}, afe_power_en, 0);
        chk({req, " acq"}, acq_en, 0);
        chk({req, " rdstart"}, readout_start, 0);
        chk({req, " clear"}, pix_master_clr, 0);
        chk({req, " stamp"}, time_stamp, 0);
        chk({req, " error"}, seq_error, 0);
    endtask

    // One full train. gap: idle cycles between crossings; bad: inject misplaced strobes.
    task automatic run_train(input int gap, input bit bad, input int err_exp);
        int k;
        int held;
        train_start = 1'b1;
        @(negedge clk);
        train_start = 1'b0;
        chk("R2 power on", afe_power_en, 1);
        chk("R2 clear pulse", pix_master_clr, 1);
        chk("R2 stamp cleared", time_stamp, 0);
        chk("R3 acq low at entry", acq_en, 0);
        for (int c = 1; c < S; c++) begin
            xing_strobe = 1'b1;   // R5: crossings during settling are ignored
            @(negedge clk);
            xing_strobe = 1'b0;
            chk("R2 clear single", pix_master_clr, 0);
            chk("R3 acq still low", acq_en, 0);
            chk("R3 power held", afe_power_en, 1);
            chk("R5 stamp in warmup", time_stamp, 0);
        end
        @(negedge clk);
        chk("R3 acq after settle", acq_en, 1);
        chk("R5 stamp at acq start", time_stamp, 0);
        k = 0;
        while (k < T) begin
            for (int g = 0; g < gap; g++) begin
                readout_done = bad;
                if (bad && k == 7 && g == 0) train_start = 1'b1;
                @(negedge clk);
                readout_done = 1'b0;
                train_start = 1'b0;
                chk("R7 done ignored in acq", acq_en, 1);
                chk("R8 no clear from late start", pix_master_clr, 0);
                chk("R4 stamp between crossings", time_stamp, exp_stamp(k));
                if (bad && k >= 7) chk("R8 error set", seq_error, 1);
            end
            xing_strobe = 1'b1;
            @(negedge clk);
            xing_strobe = 1'b0;
            k++;
            chk("R4 stamp", time_stamp, exp_stamp(k));
            if (k < T) begin
                chk("R6 acq open", acq_en, 1);
                chk("R3 power in acq", afe_power_en, 1);
                chk("R6 no early rdstart", readout_start, 0);
            end else begin
                chk("R6 acq closed", acq_en, 0);
                chk("R6 power off", afe_power_en, 0);
                chk("R6 rdstart pulse", readout_start, 1);
            end
        end
        held = exp_stamp(T);
        for (int c = 0; c < 3; c++) begin
            xing_strobe = 1'b1;  // R5: crossings in readout ignored
            if (bad && c == 1) train_start = 1'b1;
            @(negedge clk);
            xing_strobe = 1'b0;
            train_start = 1'b0;
            chk("R6 rdstart single", readout_start, 0);
            chk("R7 power stays off", afe_power_en, 0);
            chk("R8 no clear in readout", pix_master_clr, 0);
            chk("R9 stamp held", time_stamp, held);
        end
        readout_done = 1'b1;
        @(negedge clk);
        readout_done = 1'b0;
        @(negedge clk);
        chk("R9 stamp held in idle", time_stamp, held);
        chk("R7 idle power off", afe_power_en, 0);
        chk("R8 error flag", seq_error, err_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all_low("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all_low("R1 after reset");
        xing_strobe = 1'b1;  // R5: crossings in idle
        @(negedge clk);
        xing_strobe = 1'b0;
        chk("R5 idle stamp", time_stamp, 0);
        run_train(0, 1'b0, 0);
        run_train(1, 1'b0, 0);
        run_train(2, 1'b1, 1);
        run_train(3, 1'b0, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all_low("R1 R8 error cleared by reset");
        run_train(1, 1'b0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule